// File: doc/BRIEF.md
# Dual-Tone Melody Note Sequencer

This block plays songs held in a note memory. A host picks a song number from 1 to 31 and pulses a play strobe. The sequencer first reads a song pointer word from a table at the bottom of the memory. That word gives the first note address and the song tempo. The sequencer then fetches note words one after another until it reaches a note flagged as the last one.

Each note word carries a pitch index for each of two tone channels, a beat code, an effect code and an end flag. The beat code and the song tempo together set how many clock cycles the note sounds. Two square-wave generators count pulses of an external tone tick to make the two pitches. Tremolo, triple-frequency and three noise-percussion effects change the channel outputs. A time-multiplexed mix bit combines the two channels for a single speaker driver. A busy output follows either each single note or the whole song, and an interrupt pulse marks the end of a song.

Top module: `melody_seq`

## Requirements
- R1: While reset is applied and afterwards until a song is started, busy, irq, tone_a, tone_b, mix_out and mem_en are all 0.
- R2: A play pulse with a nonzero song number s, accepted while idle, issues one memory read at address s-1 for the pointer word. Bits [9:0] of the pointer word are the first note address and bits [13:10] are the tempo t. The block then reads each note word with one single-cycle read, at consecutive addresses. Read data is expected one cycle after a read.
- R3: A note word holds the channel A pitch in bits [5:0], the channel B pitch in [11:6], the beat code in [14:12], the effect code in [17:15] and the end-of-song flag in [18]. Bits [21:19] have no effect.
- R4: A note sounds for exactly beats*(t+1)*UNIT_CYC cycles, with UNIT_CYC=4 by default. Beat codes 0..5 give 1, 2, 3, 4, 6 and 8 beats, and codes 6 and 7 give 8 beats. Between two notes of a song there are two silent cycles.
- R5: A pitch index i from 0 to 45 toggles its channel every h(i) tone_tick pulses, where h(i) = B[i mod 12] >> (i div 12) and B = 64,60,57,54,51,48,45,43,40,38,36,34. An index of 46 or more is a rest and keeps the channel at 0. Every channel starts low at the first cycle of a note, and tones are 0 outside note playback.
- R6: Effect code 2 (triple) makes channel A toggle every h(i)/3 ticks, using integer division.
- R7: Effect code 1 (tremolo) forces both channels to 0 during every note cycle whose elapsed count, counted from 0 at the note's first cycle, has bit 3 set.
- R8: Effect codes 3, 4 and 5 (percussion) replace channel A during the first (t+1)*UNIT_CYC cycles of the note with bit 0, bit 2 or bit 5 of an 8-bit noise register. The noise register is set to 0xB4 at note load and shifts left once per note cycle, taking in bit7^bit5^bit4^bit3. Effect codes 0, 6 and 7 change nothing.
- R9: mix_out equals tone_a on the first cycle after reset release and then alternates between tone_b and tone_a on every clock.
- R10: With busy_mode=1, busy is high from the cycle after a play is accepted through the irq cycle. With busy_mode=0, busy is high only during note playback cycles.
- R11: irq is a one-cycle pulse in the cycle after the last playback cycle of a note whose end flag is set.
- R12: A play pulse with song number 0 returns the block to idle on the next cycle from any state, with no irq. This holds even when the pulse falls on the last cycle of the closing note.
- R13: A play pulse with a nonzero song number while a song is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| song_sel | input | 5 | Song number sampled with play; 0 means stop |
| play | input | 1 | Command strobe |
| busy_mode | input | 1 | 1: busy spans the song, 0: busy spans each note |
| tone_tick | input | 1 | Time base pulse for both tone generators |
| mem_en | output | 1 | Note memory read enable |
| mem_addr | output | 10 | Note memory read address |
| mem_rdata | input | 22 | Note memory read data, one cycle after mem_en |
| busy | output | 1 | Busy status |
| irq | output | 1 | Song-finished interrupt pulse |
| tone_a | output | 1 | Channel A output after effects |
| tone_b | output | 1 | Channel B output after effects |
| mix_out | output | 1 | Time-multiplexed mix of both channels |

## Verification
Two events can land in the same cycle: the closing note reaches its final cycle, which would raise the end-of-song interrupt, and a stop command arrives. The bench watches its reference model and drives the stop strobe exactly on that final cycle. It then expects no interrupt and an idle block on the next clock. A second overlap is a new play request that arrives while the pointer or note fetch is in flight. That request must be dropped, and the per-cycle comparison of address, busy and tone outputs shows whether it disturbed the song.

// File: rtl/melody_pkg.sv
package melody_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_PTR_CAP,
    ST_FETCH,
    ST_NOTE_CAP,
    ST_PLAY,
    ST_DONE
  } seq_state_e;

  localparam int PITCH_W   = 6;
  localparam int BEAT_W    = 3;
  localparam int FX_W      = 3;
  localparam int TEMPO_W   = 4;
  localparam int HP_W      = 7;
  localparam int NUM_SEMI  = 46;
  localparam int MAX_BEATS = 8;

  localparam logic [FX_W-1:0] FX_TREM   = 3'd1;
  localparam logic [FX_W-1:0] FX_TRIPLE = 3'd2;
  localparam logic [FX_W-1:0] FX_PERC_A = 3'd3;
  localparam logic [FX_W-1:0] FX_PERC_B = 3'd4;
  localparam logic [FX_W-1:0] FX_PERC_C = 3'd5;

  localparam logic [7:0] LFSR_SEED = 8'hB4;

  // Half-period in ticks for a semitone index; zero marks a rest.
  function automatic logic [HP_W-1:0] semi_half_period(input logic [PITCH_W-1:0] idx);
    logic [HP_W-1:0] base;
    logic [PITCH_W-1:0] octave;
    if (int'(idx) >= NUM_SEMI) begin
      return '0;
    end
    octave = idx / 6'd12;
    case (idx % 6'd12)
      6'd0:    base = 7'd64;
      6'd1:    base = 7'd60;
      6'd2:    base = 7'd57;
      6'd3:    base = 7'd54;
      6'd4:    base = 7'd51;
      6'd5:    base = 7'd48;
      6'd6:    base = 7'd45;
      6'd7:    base = 7'd43;
      6'd8:    base = 7'd40;
      6'd9:    base = 7'd38;
      6'd10:   base = 7'd36;
      default: base = 7'd34;
    endcase
    return base >> octave[1:0];
  endfunction

  function automatic logic [3:0] beat_units(input logic [BEAT_W-1:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd4;
      3'd4:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/mel_ctrl.sv
module mel_ctrl
  import melody_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SONG_W   = 5,
  parameter int UNIT_CYC = 4,
  parameter int DUR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 play,
  input  logic [SONG_W-1:0]    song_sel,
  input  logic [18:0]          rdata,
  output logic                 mem_en,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 active,
  output logic                 playing,
  output logic                 note_load,
  output logic                 irq,
  output logic [PITCH_W-1:0]   pitch_a,
  output logic [PITCH_W-1:0]   pitch_b,
  output logic [FX_W-1:0]      fx,
  output logic [DUR_W-1:0]     elapsed,
  output logic [DUR_W-1:0]     unit_len
);

  seq_state_e          st_q, st_d;
  logic [SONG_W-1:0]   song_q, song_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [TEMPO_W-1:0]  tempo_q, tempo_d;
  logic [PITCH_W-1:0]  pa_q, pa_d, pb_q, pb_d;
  logic [FX_W-1:0]     fx_q, fx_d;
  logic                last_q, last_d;
  logic [DUR_W-1:0]    elap_q, elap_d, dur_q, dur_d;
  logic [DUR_W-1:0]    note_dur;
  logic                stop_cmd;

  assign stop_cmd = play && (song_sel == '0);
  assign unit_len = DUR_W'((int'(tempo_q) + 1) * UNIT_CYC);
  assign note_dur = DUR_W'(int'(unit_len) * int'(beat_units(rdata[14:12])));

  always_comb begin
    st_d    = st_q;
    song_d  = song_q;
    addr_d  = addr_q;
    tempo_d = tempo_q;
    pa_d    = pa_q;
    pb_d    = pb_q;
    fx_d    = fx_q;
    last_d  = last_q;
    elap_d  = elap_q;
    dur_d   = dur_q;
    case (st_q)
      ST_IDLE: begin
        if (play && (song_sel != '0)) begin
          song_d = song_sel;
          st_d   = ST_PTR;
        end
      end
      ST_PTR:     st_d = ST_PTR_CAP;
      ST_PTR_CAP: begin
        addr_d  = rdata[ADDR_W-1:0];
        tempo_d = rdata[ADDR_W+TEMPO_W-1:ADDR_W];
        st_d    = ST_FETCH;
      end
      ST_FETCH:   st_d = ST_NOTE_CAP;
      ST_NOTE_CAP: begin
        pa_d   = rdata[5:0];
        pb_d   = rdata[11:6];
        fx_d   = rdata[17:15];
        last_d = rdata[18];
        dur_d  = note_dur;
        elap_d = '0;
        st_d   = ST_PLAY;
      end
      ST_PLAY: begin
        if (elap_q == dur_q - DUR_W'(1)) begin
          if (last_q) begin
            st_d = ST_DONE;
          end else begin
            addr_d = addr_q + ADDR_W'(1);
            st_d   = ST_FETCH;
          end
        end else begin
          elap_d = elap_q + DUR_W'(1);
        end
      end
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
    if (stop_cmd) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      song_q  <= '0;
      addr_q  <= '0;
      tempo_q <= '0;
      pa_q    <= '0;
      pb_q    <= '0;
      fx_q    <= '0;
      last_q  <= 1'b0;
      elap_q  <= '0;
      dur_q   <= '0;
    end else begin
      st_q    <= st_d;
      song_q  <= song_d;
      addr_q  <= addr_d;
      tempo_q <= tempo_d;
      pa_q    <= pa_d;
      pb_q    <= pb_d;
      fx_q    <= fx_d;
      last_q  <= last_d;
      elap_q  <= elap_d;
      dur_q   <= dur_d;
    end
  end

  assign mem_en    = (st_q == ST_PTR) || (st_q == ST_FETCH);
  assign mem_addr  = (st_q == ST_PTR) ? (ADDR_W'(song_q) - ADDR_W'(1)) : addr_q;
  assign active    = (st_q != ST_IDLE);
  assign playing   = (st_q == ST_PLAY);
  assign note_load = (st_q == ST_NOTE_CAP);
  assign irq       = (st_q == ST_DONE);
  assign pitch_a   = pa_q;
  assign pitch_b   = pb_q;
  assign fx        = fx_q;
  assign elapsed   = elap_q;

endmodule

// File: rtl/mel_tone.sv
module mel_tone #(
  parameter int HP_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            run,
  input  logic            tick,
  input  logic [HP_W-1:0] half_period,
  output logic            sq
);

  logic [HP_W-1:0] cnt_q, cnt_d;
  logic            sq_q, sq_d;
  logic            step_en;

  assign step_en = run && tick && (half_period != '0);

  always_comb begin
    cnt_d = cnt_q;
    sq_d  = sq_q;
    if (clear) begin
      cnt_d = '0;
      sq_d  = 1'b0;
    end else if (step_en) begin
      if (cnt_q >= half_period - HP_W'(1)) begin
        cnt_d = '0;
        sq_d  = ~sq_q;
      end else begin
        cnt_d = cnt_q + HP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sq_q  <= sq_d;
    end
  end

  assign sq = sq_q;

endmodule

// File: rtl/mel_fx.sv
module mel_fx
  import melody_pkg::*;
#(
  parameter int DUR_W    = 10,
  parameter int TREM_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [FX_W-1:0]  fx,
  input  logic [DUR_W-1:0] elapsed,
  input  logic [DUR_W-1:0] unit_len,
  input  logic             sq_a,
  input  logic             sq_b,
  output logic             tone_a,
  output logic             tone_b,
  output logic             mix_out
);

  logic [7:0] lfsr_q, lfsr_d;
  logic       phase_q, phase_d;
  logic       noise, perc_on, trem_off;

  always_comb begin
    lfsr_d = lfsr_q;
    if (load) begin
      lfsr_d = LFSR_SEED;
    end else if (run) begin
      lfsr_d = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    end
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= LFSR_SEED;
      phase_q <= 1'b0;
    end else begin
      lfsr_q  <= lfsr_d;
      phase_q <= phase_d;
    end
  end

  always_comb begin
    case (fx)
      FX_PERC_A: noise = lfsr_q[0];
      FX_PERC_B: noise = lfsr_q[2];
      FX_PERC_C: noise = lfsr_q[5];
      default:   noise = 1'b0;
    endcase
  end

  assign perc_on  = (fx >= FX_PERC_A) && (fx <= FX_PERC_C) && (elapsed < unit_len);
  assign trem_off = (fx == FX_TREM) && elapsed[TREM_BIT];
  assign tone_a   = run && !trem_off && (perc_on ? noise : sq_a);
  assign tone_b   = run && !trem_off && sq_b;
  assign mix_out  = phase_q ? tone_b : tone_a;

endmodule

// File: rtl/melody_seq.sv
module melody_seq
  import melody_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SONG_W   = 5,
  parameter int WORD_W   = 22,
  parameter int UNIT_CYC = 4,
  parameter int TREM_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SONG_W-1:0] song_sel,
  input  logic              play,
  input  logic              busy_mode,
  input  logic              tone_tick,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              irq,
  output logic              tone_a,
  output logic              tone_b,
  output logic              mix_out
);

  localparam int DUR_W  = $clog2(MAX_BEATS * (1 << TEMPO_W) * UNIT_CYC + 1);
  localparam int NUM_CH = 2;

  logic [1:0]          sync_q;
  logic                rst_int_n;
  logic                active, playing, note_load;
  logic [PITCH_W-1:0]  pitch_a, pitch_b;
  logic [FX_W-1:0]     fx;
  logic [DUR_W-1:0]    elapsed, unit_len;
  logic [HP_W-1:0]     hp_base_a, hp_base_b;
  logic [HP_W-1:0]     hp [NUM_CH];
  logic [NUM_CH-1:0]   sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = sync_q[1];

  mel_ctrl #(
    .ADDR_W  (ADDR_W),
    .SONG_W  (SONG_W),
    .UNIT_CYC(UNIT_CYC),
    .DUR_W   (DUR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .play     (play),
    .song_sel (song_sel),
    .rdata    (mem_rdata[18:0]),
    .mem_en   (mem_en),
    .mem_addr (mem_addr),
    .active   (active),
    .playing  (playing),
    .note_load(note_load),
    .irq      (irq),
    .pitch_a  (pitch_a),
    .pitch_b  (pitch_b),
    .fx       (fx),
    .elapsed  (elapsed),
    .unit_len (unit_len)
  );

  assign hp_base_a = semi_half_period(pitch_a);
  assign hp_base_b = semi_half_period(pitch_b);
  assign hp[0] = (fx == FX_TRIPLE) ? (hp_base_a / HP_W'(3)) : hp_base_a;
  assign hp[1] = hp_base_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    mel_tone #(.HP_W(HP_W)) u_tone (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .clear      (note_load),
      .run        (playing),
      .tick       (tone_tick),
      .half_period(hp[c]),
      .sq         (sq[c])
    );
  end

  mel_fx #(
    .DUR_W   (DUR_W),
    .TREM_BIT(TREM_BIT)
  ) u_fx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (note_load),
    .run     (playing),
    .fx      (fx),
    .elapsed (elapsed),
    .unit_len(unit_len),
    .sq_a    (sq[0]),
    .sq_b    (sq[1]),
    .tone_a  (tone_a),
    .tone_b  (tone_b),
    .mix_out (mix_out)
  );

  assign busy = busy_mode ? active : playing;

endmodule

// File: rtl/mel_chk.sv
module mel_chk #(
  parameter int SONG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              play,
  input logic [SONG_W-1:0] song_sel,
  input logic              busy_mode,
  input logic              busy,
  input logic              irq,
  input logic              mem_en,
  input logic              tone_a,
  input logic              tone_b
);

  // R2: every memory read lasts one cycle
  assert_fetch_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);

  // R11: interrupt is a single-cycle pulse
  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10: in song mode busy covers the interrupt cycle
  assert_busy_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mode && irq) |-> busy);

  // R1 R10: no tone while the song-mode busy flag is low
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mode && !busy) |-> (!tone_a && !tone_b));

  // R12: stop command idles the block with no interrupt
  assert_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (play && song_sel == '0) |=> (!irq && !(busy_mode && busy)));

  // R13: a new start while a song runs does not end it
  assert_ignore_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mode && busy && !irq && play && song_sel != '0) |=> (busy || !busy_mode));

endmodule

bind melody_seq mel_chk #(.SONG_W(SONG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .play     (play),
  .song_sel (song_sel),
  .busy_mode(busy_mode),
  .busy     (busy),
  .irq      (irq),
  .mem_en   (mem_en),
  .tone_a   (tone_a),
  .tone_b   (tone_b)
);

// File: tb/melody_seq_bench.sv
module melody_seq_bench;

  localparam int UNIT = 4;
  localparam int S_IDLE = 0, S_PTR = 1, S_PCAP = 2, S_FETCH = 3, S_NCAP = 4, S_PLAY = 5, S_DONE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  song_sel = '0;
  logic        play = 1'b0;
  logic        busy_mode = 1'b1;
  logic        tone_tick = 1'b1;
  logic        mem_en;
  logic [9:0]  mem_addr;
  logic [21:0] mem_rdata;
  logic        busy, irq, tone_a, tone_b, mix_out;

  logic [21:0] mem [1024];

  int n_chk = 0, n_fail = 0, cyc = 0, irq_seen = 0, busy_cyc = 0;
  int tick_mode = 0;

  always #2 clk = ~clk;

  melody_seq u_melody_seq (
    .clk(clk), .rst_n(rst_n), .song_sel(song_sel), .play(play),
    .busy_mode(busy_mode), .tone_tick(tone_tick), .mem_en(mem_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .irq(irq),
    .tone_a(tone_a), .tone_b(tone_b), .mix_out(mix_out)
  );

  always @(posedge clk) if (mem_en) mem_rdata <= mem[mem_addr];

  // ---------------- reference model ----------------
  int m_rs = 0, m_st = S_IDLE, m_song = 0, m_addr = 0, m_tempo = 0;
  int m_elap = 0, m_dur = 0, m_ca = 0, m_cb = 0, m_phase = 0;
  logic [21:0] m_rdv = '0;
  logic [5:0]  m_pa = '0, m_pb = '0;
  logic [2:0]  m_fx = '0;
  logic        m_last = 1'b0, m_sa = 1'b0, m_sb = 1'b0;
  logic [7:0]  m_lfsr = 8'hB4;

  function automatic int half_per(logic [5:0] i);
    int tab [12] = '{64, 60, 57, 54, 51, 48, 45, 43, 40, 38, 36, 34};
    if (i >= 46) return 0;
    return tab[i % 12] >> (i / 12);
  endfunction

  function automatic int beats_of(logic [2:0] c);
    int b [8] = '{1, 2, 3, 4, 6, 8, 8, 8};
    return b[c];
  endfunction

  function automatic int hp_a();
    int h = half_per(m_pa);
    if (m_fx == 3'd2) h = h / 3;
    return h;
  endfunction

  task automatic model_step();
    logic [21:0] rd = m_rdv;
    bit stop = play && (song_sel == 0);
    int ha = hp_a();
    int hb = half_per(m_pb);
    if (m_st == S_PTR) m_rdv = mem[m_song - 1];
    else if (m_st == S_FETCH) m_rdv = mem[m_addr];
    if (m_st == S_PLAY) begin
      if (tone_tick && ha != 0) begin
        if (m_ca >= ha - 1) begin m_ca = 0; m_sa = ~m_sa; end else m_ca++;
      end
      if (tone_tick && hb != 0) begin
        if (m_cb >= hb - 1) begin m_cb = 0; m_sb = ~m_sb; end else m_cb++;
      end
      m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    end
    case (m_st)
      S_IDLE: if (play && song_sel != 0) begin m_song = song_sel; m_st = S_PTR; end
      S_PTR:  m_st = S_PCAP;
      S_PCAP: begin m_addr = rd[9:0]; m_tempo = rd[13:10]; m_st = S_FETCH; end
      S_FETCH: m_st = S_NCAP;
      S_NCAP: begin
        m_pa = rd[5:0]; m_pb = rd[11:6]; m_fx = rd[17:15]; m_last = rd[18];
        m_dur = beats_of(rd[14:12]) * (m_tempo + 1) * UNIT;
        m_elap = 0; m_ca = 0; m_cb = 0; m_sa = 0; m_sb = 0; m_lfsr = 8'hB4;
        m_st = S_PLAY;
      end
      S_PLAY: begin
        if (m_elap == m_dur - 1) begin
          if (m_last) m_st = S_DONE;
          else begin m_addr = (m_addr + 1) % 1024; m_st = S_FETCH; end
        end else m_elap++;
      end
      default: m_st = S_IDLE;
    endcase
    if (stop) m_st = S_IDLE;
    m_phase ^= 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_st = S_IDLE; m_phase = 0;
    end else begin
      if (m_rs == 2) model_step();
      if (m_rs < 2) m_rs++;
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit pl, gate, perc, ea, eb, noise;
    int ex_addr;
    pl = (m_st == S_PLAY);
    gate = !(m_fx == 3'd1 && m_elap[3]);
    perc = (m_fx >= 3 && m_fx <= 5) && (m_elap < (m_tempo + 1) * UNIT);
    noise = (m_fx == 3) ? m_lfsr[0] : (m_fx == 4) ? m_lfsr[2] : m_lfsr[5];
    ea = pl && gate && (perc ? noise : m_sa);
    eb = pl && gate && m_sb;
    chk("R2 mem_en", mem_en, (m_st == S_PTR || m_st == S_FETCH));
    if (m_st == S_PTR || m_st == S_FETCH) begin
      ex_addr = (m_st == S_PTR) ? m_song - 1 : m_addr;
      chk("R2 mem_addr", mem_addr, ex_addr);
    end
    chk("R10 busy", busy, busy_mode ? (m_st != S_IDLE) : pl);
    chk("R11 irq", irq, m_st == S_DONE);
    chk("R5 R6 R7 R8 tone_a", tone_a, ea);
    chk("R5 R7 tone_b", tone_b, eb);
    chk("R9 mix_out", mix_out, m_phase ? eb : ea);
    if (irq) irq_seen++;
    if (busy) busy_cyc++;
    cyc++;
    if (tick_mode == 0) tone_tick = 1'b1;
    else if (tick_mode == 1) tone_tick = (cyc % 3 == 0);
    else tone_tick = ($urandom % 2) == 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [21:0] note(int pa, int pb, int bt, int fx, int last, int rsv);
    return {3'(rsv), 1'(last), 3'(fx), 3'(bt), 6'(pb), 6'(pa)};
  endfunction

  task automatic start(int s);
    @(negedge clk); song_sel = 5'(s); play = 1'b1;
    @(negedge clk); play = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_st != S_IDLE);
    @(negedge clk);
  endtask

  initial begin
    int irq0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[0]  = 22'(40)  | (22'(0)  << 10);
    mem[1]  = 22'(60)  | (22'(2)  << 10);
    mem[2]  = 22'(80)  | (22'(1)  << 10);
    mem[30] = 22'(100) | (22'(15) << 10);
    mem[40] = note(0, 12, 0, 0, 0, 0);
    mem[41] = note(45, 46, 1, 0, 0, 0);
    mem[42] = note(20, 33, 3, 0, 1, 0);
    mem[60] = note(5, 9, 2, 1, 0, 0);
    mem[61] = note(30, 30, 4, 2, 0, 0);
    mem[62] = note(63, 10, 5, 3, 0, 0);
    mem[63] = note(7, 8, 6, 4, 0, 7);
    mem[64] = note(11, 2, 7, 5, 0, 5);
    mem[65] = note(3, 3, 0, 6, 1, 0);
    mem[80] = note(15, 22, 0, 0, 1, 0);
    mem[100] = note(44, 1, 0, 7, 0, 0);
    mem[101] = note(45, 45, 1, 0, 1, 0);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0);
    chk("R1 tones", tone_a | tone_b | mix_out, 0); chk("R1 mem_en", mem_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R4 R5 R13: song 1, song mode, a start request during the pointer fetch is ignored
    busy_mode = 1'b1; tick_mode = 0;
    @(negedge clk); song_sel = 5'd1; play = 1'b1;
    @(negedge clk); song_sel = 5'd2;
    @(negedge clk); play = 1'b0;
    wait_idle();
    chk("R11 R13 irq count song1", irq_seen, 1);

    // R3 R4 R6 R7 R8 R10: song 2 in note mode, sparse ticks, duration sum 34 beats * 12
    busy_mode = 1'b0; tick_mode = 1; busy_cyc = 0;
    start(2);
    wait_idle();
    chk("R4 R10 busy cycles song2", busy_cyc, 408);
    chk("R11 irq count song2", irq_seen, 2);

    // R12: stop on the final cycle of the closing note
    busy_mode = 1'b1; tick_mode = 0;
    start(3);
    do @(negedge clk); while (!(m_st == S_PLAY && m_elap == m_dur - 1));
    irq0 = irq_seen;
    song_sel = 5'd0; play = 1'b1;
    @(negedge clk); play = 1'b0;
    chk("R12 busy after stop", busy, 0);
    repeat (3) @(negedge clk);
    chk("R12 no irq on collision", irq_seen, irq0);

    // R12: stop in mid-song, and stop while idle
    start(31);
    repeat (30) @(negedge clk);
    song_sel = 5'd0; play = 1'b1;
    @(negedge clk); play = 1'b0;
    chk("R12 mid-song stop", busy, 0);
    start(0);
    repeat (2) @(negedge clk);
    chk("R12 idle stop", busy, 0);

    // R5 R10: song 31, note mode, random ticks, top of the pitch range
    busy_mode = 1'b0; tick_mode = 2;
    start(31);
    wait_idle();
    chk("R11 irq count final", irq_seen, irq0 + 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule